// File: doc/BRIEF.md
# PWM Action Qualifier with Software Force

This block sits after a PWM time base. It turns time-base events into two output levels, A and B. On each prescaled tick it looks at four events: the counter at zero, the counter at the period, the counter matching compare value 0 while counting up, and the counter matching compare value 1 while counting up. Each output has its own 16-bit action register. That register gives every event a 2-bit action: no change, clear, set or toggle. Both outputs share one period, so they always run at the same frequency. They can still differ in duty and polarity through their own action fields and the two compare registers.

A continuous software force can hold either output at a fixed low or high level, whatever the events do. Force values are first written to a shadow register. They become active under a selectable reload policy: at counter zero, at counter period, at either of these, or on the next tick. Software writes all configuration through a simple write-only port. The time base itself (counter, direction, zero and period strobes, prescaled tick) is an input to the block.

Top module: `pwm_action_qual`

## Requirements
- R1: Action codes are 2 bits wide: 00 leaves the output unchanged, 01 drives it low, 10 drives it high, 11 inverts it. The output register updates only on the clock edge of a cycle where `tick` is high, and it uses the register values held before any write in that same cycle.
- R2: In an output's action register, the field for each event sits at a fixed place: counter zero in bits [1:0], counter period in [3:2], compare 0 up-match in [5:4], compare 1 up-match in [9:8]. Bits [7:6] and [15:10] have no effect.
- R3: A compare event fires only on a tick where `cnt_up` is 1 and `cnt` equals that compare register. A match while counting down has no effect on either output.
- R4: When several events with non-zero actions hit one output on the same tick, only one action applies. Compare 1 beats compare 0, compare 0 beats period, and period beats zero. An event whose action is 00 does not block a lower-priority one.
- R5: The force register (address 4) holds output A's force in bits [1:0] and output B's force in bits [3:2]. The code 01 forces low, 10 forces high, and 00 and 11 mean no force. An active force overrides every event action on each tick.
- R6: A written force value first goes to a shadow register and becomes active on a tick chosen by the reload field, bits [7:6] of the register at address 5. The codes are: 00 on a tick with counter zero, 01 on a tick with counter period, 10 on a tick with either, 11 on the next tick. A force that becomes active on a tick already decides the output level of that tick.
- R7: On cycles where `tick` is low, both outputs and the active force keep their values.
- R8: After reset, both outputs are low, and all action, compare, force and reload registers are zero.
- R9: Register addresses: 0 is action A, 1 is action B, 2 is compare 0, 3 is compare 1, 4 is force, 5 is reload mode. A register loads `wr_data` at the clock edge where `wr_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaled time-base tick; events are taken only when high |
| cnt | input | 16 | Time-base counter value |
| cnt_up | input | 1 | 1 while the counter counts up |
| at_zero | input | 1 | Counter-equals-zero strobe |
| at_period | input | 1 | Counter-equals-period strobe |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| out_a | output | 1 | PWM output A |
| out_b | output | 1 | PWM output B |

## Verification
The bench aims at compare matches in up-down counting, where a design that ignored direction would toggle twice per period. It aims at compare values placed on zero or on the period, so that several events coincide; a design with the wrong priority, or one that let a 00 action mask a lower event, would settle on the wrong level. Force reloads are exercised in every mode. A design that applied the shadow at once, or at the wrong strobe, would switch the output ticks early or late. Slowed ticks and set-but-unused register bits expose a design that acts between ticks or decodes the wrong field.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;

  localparam int ACT_W = 16;
  localparam int NCH   = 2;
  localparam int NCMP  = 2;

  // action field positions inside an action register
  localparam int FLD_ZRO = 0;
  localparam int FLD_PRD = 2;
  localparam int FLD_CM0 = 4;
  localparam int FLD_CM1 = 8;

  // register addresses
  localparam int ADR_ACT = 0;
  localparam int ADR_CMP = 2;
  localparam int ADR_FRC = 4;
  localparam int ADR_RLD = 5;
  localparam int RLD_LSB = 6;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } act_e;

  typedef enum logic [1:0] {
    RLD_ZERO   = 2'b00,
    RLD_PRD    = 2'b01,
    RLD_EITHER = 2'b10,
    RLD_NOW    = 2'b11
  } rld_e;

  function automatic act_e pick_act(input logic [ACT_W-1:0] r,
                                    input logic ez, input logic ep,
                                    input logic e0, input logic e1);
    act_e a;
    a = ACT_NONE;
    if (e1 && r[FLD_CM1 +: 2] != 2'b00)      a = act_e'(r[FLD_CM1 +: 2]);
    else if (e0 && r[FLD_CM0 +: 2] != 2'b00) a = act_e'(r[FLD_CM0 +: 2]);
    else if (ep && r[FLD_PRD +: 2] != 2'b00) a = act_e'(r[FLD_PRD +: 2]);
    else if (ez && r[FLD_ZRO +: 2] != 2'b00) a = act_e'(r[FLD_ZRO +: 2]);
    return a;
  endfunction

  function automatic logic apply_act(input act_e a, input logic cur);
    logic n;
    case (a)
      ACT_LOW:    n = 1'b0;
      ACT_HIGH:   n = 1'b1;
      ACT_TOGGLE: n = ~cur;
      default:    n = cur;
    endcase
    return n;
  endfunction

  function automatic logic force_on(input logic [1:0] f);
    return f[1] ^ f[0];
  endfunction

  function automatic logic force_lvl(input logic [1:0] f);
    return f[1];
  endfunction

endpackage

// File: rtl/aq_regs.sv
module aq_regs
  import pwm_aq_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [ACT_W-1:0]               wr_data,
  output logic [NCH-1:0][ACT_W-1:0]      act_q,
  output logic [NCMP-1:0][CNT_W-1:0]     cmp_q,
  output logic [2*NCH-1:0]               frc_sh_q,
  output rld_e                           mode_q
);

  localparam int FRC_W = 2 * NCH;

  generate
    for (genvar ch = 0; ch < NCH; ch++) begin : g_act
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_q[ch] <= '0;
        else if (wr_en && int'(wr_addr) == ADR_ACT + ch) act_q[ch] <= wr_data;
      end
    end
    for (genvar k = 0; k < NCMP; k++) begin : g_cmp
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmp_q[k] <= '0;
        else if (wr_en && int'(wr_addr) == ADR_CMP + k) cmp_q[k] <= wr_data[CNT_W-1:0];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frc_sh_q <= '0;
      mode_q   <= RLD_ZERO;
    end else if (wr_en) begin
      if (int'(wr_addr) == ADR_FRC) frc_sh_q <= wr_data[FRC_W-1:0];
      if (int'(wr_addr) == ADR_RLD) mode_q   <= rld_e'(wr_data[RLD_LSB +: 2]);
    end
  end

endmodule

// File: rtl/aq_event_dec.sv
module aq_event_dec
  import pwm_aq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                       tick,
  input  logic [CNT_W-1:0]           cnt,
  input  logic                       cnt_up,
  input  logic                       at_zero,
  input  logic                       at_period,
  input  logic [NCMP-1:0][CNT_W-1:0] cmp_q,
  output logic                       ev_zero,
  output logic                       ev_prd,
  output logic [NCMP-1:0]            ev_cmp
);

  assign ev_zero = tick && at_zero;
  assign ev_prd  = tick && at_period;

  generate
    for (genvar k = 0; k < NCMP; k++) begin : g_cmp
      assign ev_cmp[k] = tick && cnt_up && (cnt == cmp_q[k]);
    end
  endgenerate

endmodule

// File: rtl/aq_force_ctl.sv
module aq_force_ctl
  import pwm_aq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               at_zero,
  input  logic               at_period,
  input  rld_e               mode_q,
  input  logic [2*NCH-1:0]   frc_sh_q,
  output logic [2*NCH-1:0]   frc_now,
  output logic [2*NCH-1:0]   frc_act_q
);

  logic load;

  always_comb begin
    case (mode_q)
      RLD_ZERO:   load = at_zero;
      RLD_PRD:    load = at_period;
      RLD_EITHER: load = at_zero || at_period;
      default:    load = 1'b1;
    endcase
  end

  // force in effect on the current tick
  assign frc_now = (tick && load) ? frc_sh_q : frc_act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    frc_act_q <= '0;
    else if (tick) frc_act_q <= frc_now;
  end

endmodule

// File: rtl/aq_out_chan.sv
module aq_out_chan
  import pwm_aq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [ACT_W-1:0] act_reg,
  input  logic             ev_zero,
  input  logic             ev_prd,
  input  logic [NCMP-1:0]  ev_cmp,
  input  logic [1:0]       frc,
  output logic             out_q
);

  act_e sel_act;
  logic out_nxt;

  assign sel_act = pick_act(act_reg, ev_zero, ev_prd, ev_cmp[0], ev_cmp[1]);
  assign out_nxt = force_on(frc) ? force_lvl(frc) : apply_act(sel_act, out_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    out_q <= 1'b0;
    else if (tick) out_q <= out_nxt;
  end

endmodule

// File: rtl/pwm_action_qual.sv
module pwm_action_qual
  import pwm_aq_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              cnt_up,
  input  logic              at_zero,
  input  logic              at_period,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ACT_W-1:0]  wr_data,
  output logic              out_a,
  output logic              out_b
);

  logic [NCH-1:0][ACT_W-1:0]  act_q;
  logic [NCMP-1:0][CNT_W-1:0] cmp_q;
  logic [2*NCH-1:0]           frc_sh_q;
  rld_e                       mode_q;
  logic                       ev_zero;
  logic                       ev_prd;
  logic [NCMP-1:0]            ev_cmp;
  logic [2*NCH-1:0]           frc_now;
  logic [2*NCH-1:0]           frc_act_q;
  logic [NCH-1:0]             out_q;

  aq_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .act_q(act_q), .cmp_q(cmp_q),
    .frc_sh_q(frc_sh_q), .mode_q(mode_q)
  );

  aq_event_dec #(.CNT_W(CNT_W)) u_evt (
    .tick(tick), .cnt(cnt), .cnt_up(cnt_up), .at_zero(at_zero),
    .at_period(at_period), .cmp_q(cmp_q), .ev_zero(ev_zero),
    .ev_prd(ev_prd), .ev_cmp(ev_cmp)
  );

  aq_force_ctl u_frc (
    .clk(clk), .rst_n(rst_n), .tick(tick), .at_zero(at_zero),
    .at_period(at_period), .mode_q(mode_q), .frc_sh_q(frc_sh_q),
    .frc_now(frc_now), .frc_act_q(frc_act_q)
  );

  generate
    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
      aq_out_chan u_chan (
        .clk(clk), .rst_n(rst_n), .tick(tick), .act_reg(act_q[ch]),
        .ev_zero(ev_zero), .ev_prd(ev_prd), .ev_cmp(ev_cmp),
        .frc(frc_now[2*ch +: 2]), .out_q(out_q[ch])
      );
    end
  endgenerate

  assign out_a = out_q[0];
  assign out_b = out_q[1];

endmodule

// File: rtl/aq_checker.sv
module aq_checker
  import pwm_aq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             cnt_up,
  input logic             at_zero,
  input rld_e             mode_q,
  input logic [3:0]       frc_now,
  input logic [3:0]       frc_act_q,
  input logic [NCMP-1:0]  ev_cmp,
  input logic [ACT_W-1:0] act_a,
  input logic             out_a,
  input logic             out_b
);

  // R3
  cmp_up_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cmp != '0) |-> (cnt_up && tick));

  // R5
  force_a_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (frc_now[1] ^ frc_now[0])) |=> (out_a == $past(frc_now[1])));

  // R5
  force_b_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (frc_now[3] ^ frc_now[2])) |=> (out_b == $past(frc_now[3])));

  // R7
  hold_off_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(out_a) && $stable(out_b) && $stable(frc_act_q)));

  // R6
  reload_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode_q == RLD_ZERO && !at_zero) |=> $stable(frc_act_q));

  // R4
  cmp1_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ev_cmp[1] && act_a[9:8] == 2'b10 && !(frc_now[1] ^ frc_now[0]))
      |=> out_a);

  // R8
  reset_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_a && !out_b && frc_act_q == '0));

endmodule

bind pwm_action_qual aq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_up(cnt_up),
  .at_zero(at_zero), .mode_q(mode_q), .frc_now(frc_now),
  .frc_act_q(frc_act_q), .ev_cmp(ev_cmp), .act_a(act_q[0]),
  .out_a(out_a), .out_b(out_b)
);

// File: tb/pwm_action_qual_tb.sv
module pwm_action_qual_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [15:0] cnt = '0;
  logic        cnt_up = 1'b1;
  logic        at_zero = 1'b0;
  logic        at_period = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        out_a;
  logic        out_b;

  pwm_action_qual u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .cnt_up(cnt_up),
    .at_zero(at_zero), .at_period(at_period), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .out_a(out_a), .out_b(out_b)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // time base owned by the bench
  int tb_c = 0, tb_prd = 9, tb_div = 0, tb_tdiv = 1;
  bit tb_dir = 1, tb_updown = 0;

  // reference model state
  int m_act[2], m_cmp[2], m_sh = 0, m_fa = 0, m_mode = 0, m_out[2];

  // pending write
  bit p_wen = 0; int p_addr = 0, p_data = 0;

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(string tag);
    bit t, ld, z, p;
    int f, rv, code;
    @(negedge clk);
    t = (tb_div == 0);
    z = (tb_c == 0);
    p = (tb_c == tb_prd);
    tick = t; cnt = 16'(tb_c); cnt_up = tb_dir; at_zero = z; at_period = p;
    wr_en = p_wen; wr_addr = 3'(p_addr); wr_data = 16'(p_data);
    if (t) begin
      case (m_mode)
        0: ld = z;
        1: ld = p;
        2: ld = z || p;
        default: ld = 1;
      endcase
      if (ld) m_fa = m_sh;
      for (int ch = 0; ch < 2; ch++) begin
        f = (m_fa >> (2*ch)) & 3;
        if (f == 1) m_out[ch] = 0;
        else if (f == 2) m_out[ch] = 1;
        else begin
          rv = m_act[ch];
          code = 0;
          if (tb_dir && tb_c == m_cmp[1] && ((rv >> 8) & 3) != 0) code = (rv >> 8) & 3;
          else if (tb_dir && tb_c == m_cmp[0] && ((rv >> 4) & 3) != 0) code = (rv >> 4) & 3;
          else if (p && ((rv >> 2) & 3) != 0) code = (rv >> 2) & 3;
          else if (z && (rv & 3) != 0) code = rv & 3;
          if (code == 1) m_out[ch] = 0;
          else if (code == 2) m_out[ch] = 1;
          else if (code == 3) m_out[ch] = 1 - m_out[ch];
        end
      end
    end
    if (p_wen) begin
      case (p_addr)
        0: m_act[0] = p_data;
        1: m_act[1] = p_data;
        2: m_cmp[0] = p_data;
        3: m_cmp[1] = p_data;
        4: m_sh = p_data & 15;
        5: m_mode = (p_data >> 6) & 3;
        default: ;
      endcase
    end
    p_wen = 0;
    @(posedge clk);
    #1;
    check(tag, int'(out_a), m_out[0], "out_a");
    check(tag, int'(out_b), m_out[1], "out_b");
    tb_div = (tb_div + 1) % tb_tdiv;
    if (t) begin
      if (!tb_updown) tb_c = (tb_c == tb_prd) ? 0 : tb_c + 1;
      else if (tb_dir) begin
        if (tb_c == tb_prd) begin tb_dir = 0; tb_c = tb_c - 1; end
        else tb_c = tb_c + 1;
      end else begin
        if (tb_c == 0) begin tb_dir = 1; tb_c = 1; end
        else tb_c = tb_c - 1;
      end
    end
  endtask

  task automatic wr(int a, int d, string tag);
    p_wen = 1; p_addr = a; p_data = d;
    step(tag);
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  initial begin
    m_act[0] = 0; m_act[1] = 0; m_cmp[0] = 0; m_cmp[1] = 0;
    m_out[0] = 0; m_out[1] = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R8", int'(out_a), 0, "out_a in reset");
    check("R8", int'(out_b), 0, "out_b in reset");
    @(negedge clk);
    rst_n = 1'b1;
    // R8: registers start at zero, so events change nothing
    run(25, "R8");
    // R1 R2 R9: normal polarity on A
    wr(2, 4, "R9");
    wr(0, 16'h001A, "R1");
    run(40, "R1");
    // R2: inverted polarity on B using compare 1
    wr(3, 6, "R9");
    wr(1, 16'h0205, "R2");
    run(40, "R2");
    // R2: unused bits set, behaviour unchanged
    wr(0, 16'hFCDA, "R2");
    run(30, "R2");
    // R1: toggle actions
    wr(0, 16'h0003, "R1");
    wr(1, 16'h000C, "R1");
    run(40, "R1");
    // R3: up-down counting, compare toggles only when counting up
    tb_updown = 1;
    wr(0, 16'h0030, "R3");
    wr(1, 16'h0300, "R3");
    run(60, "R3");
    tb_updown = 0; tb_dir = 1; tb_c = 0;
    // R4: coincident events at zero
    wr(2, 0, "R4");
    wr(3, 0, "R4");
    wr(0, 16'h0213, "R4");
    wr(1, 16'h0013, "R4");
    run(40, "R4");
    // R4: compare 1 on the period, zero action in compare 1 field passes through
    wr(3, 9, "R4");
    wr(1, 16'h0204, "R4");
    wr(0, 16'h000B, "R4");
    run(40, "R4");
    // R7: slowed ticks
    tb_tdiv = 3; tb_div = 0;
    wr(2, 4, "R7");
    wr(0, 16'h001A, "R7");
    wr(1, 16'h0205, "R7");
    run(90, "R7");
    tb_tdiv = 1; tb_div = 0;
    // R5 R6: immediate reload
    wr(5, 16'h00C0, "R6");
    wr(4, 16'h0002, "R5");
    run(25, "R5");
    wr(4, 16'h0004, "R5");
    run(25, "R5");
    wr(4, 16'h000F, "R5");
    run(25, "R5");
    // R6: reload at zero, at period, at either
    wr(5, 16'h0000, "R6");
    wr(4, 16'h0009, "R6");
    run(30, "R6");
    wr(5, 16'h0040, "R6");
    wr(4, 16'h0006, "R6");
    run(30, "R6");
    wr(5, 16'h0080, "R6");
    wr(4, 16'h0000, "R6");
    run(30, "R6");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule